// File: doc/BRIEF.md
# Interrupt Mask and Acceptance Logic

This block sits beside the processor pipeline and decides the cycle in which a pending interrupt request is taken. It compares the request level from the interrupt controller with a 3-bit priority mask that software can write. It sends a one-cycle accept pulse to the exception sequencer. Levels 1 to 6 are maskable. Level 7 cannot be masked and is taken on a rising edge, so a held level-7 line is serviced once.

After an exception is entered, the core raises a flag while the first handler instruction runs, and interrupt sampling is suspended for that time. A level-7 edge that arrives in this window is latched and taken once the window closes. On exception entry the block saves the mask in a one-deep register. If the static auto-mask enable is set, it also forces the mask to 7, so the handler needs no instruction to shut out further maskable requests. The return strobe copies the saved mask back.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the mask reads 7 and no accept pulse is issued.
- R2: A write strobe loads the write data into the mask at the next clock edge.
- R3: A request at level 1 to 6 is accepted only when its level is strictly greater than the mask. Level 0 is never accepted. The accept pulse appears in the cycle after the clock edge at which the condition held.
- R4: Level 7 (all ones) is accepted on a rising edge, whatever the mask is. Holding level 7 does not cause a second accept.
- R5: No accept is issued for any clock edge at which the first-handler-instruction flag is high.
- R6: A level-7 edge that arrives while sampling is suspended is held pending. It is accepted at the first edge where the flag is low.
- R7: Once an accept has been issued, no further accept is issued until the exception-entry strobe has been seen.
- R8: Exception entry saves the current mask. If auto-mask is enabled, entry loads 7 into the mask. If auto-mask is disabled, entry leaves the mask unchanged.
- R9: The return strobe loads the saved mask back into the mask.
- R10: When strobes coincide, exception entry wins over return, and return wins over a mask write.
- R11: Every accept pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_level | input | 3 | Requested level from the interrupt controller (0 = none) |
| mask_wr | input | 1 | Software mask write strobe |
| mask_wdata | input | 3 | Mask write data |
| exc_entry | input | 1 | Exception entry strobe |
| first_instr | input | 1 | High while the first handler instruction executes |
| exc_return | input | 1 | Return-from-exception strobe |
| auto_mask_en | input | 1 | Static enable that forces the mask to 7 on entry |
| accept | output | 1 | One-cycle pulse: request taken |
| cur_mask | output | 3 | Current mask value |

## Verification
The assertions assume that every accept is answered by an exception-entry strobe before the core expects another accept. They also assume that strobes are single-cycle and that req_level changes only between clock edges. The stimulus keeps to these rules: each scenario task closes its accepted request with an entry pulse and drives every input one time unit after a rising edge. Strobes are coincident only in the priority scenario, which checks the ordering and nothing else.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic logic is_top(input lvl_t lvl);
    return lvl == LVL_TOP;
  endfunction

  // maskable level strictly above mask; 0 and the top level excluded
  function automatic logic beats_mask(input lvl_t lvl, input lvl_t mask);
    return (lvl != '0) && !is_top(lvl) && (lvl > mask);
  endfunction
endpackage

// File: rtl/irq_top_edge.sv
module irq_top_edge
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t req_level,
  input  logic first_instr,
  input  logic take_top,
  output logic top_live
);
  logic prev_top_q, pend_q, top_rise;

  assign top_rise = is_top(req_level) && !prev_top_q;
  assign top_live = pend_q || top_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_top_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      prev_top_q <= is_top(req_level);
      pend_q     <= top_live && !take_top;
    end
  end

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rise && first_instr) |=> pend_q); // R6
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mask_wr,
  input  lvl_t mask_wdata,
  input  logic exc_entry,
  input  logic exc_return,
  input  logic auto_mask_en,
  output lvl_t mask_q
);
  lvl_t saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= LVL_TOP;
      saved_q <= LVL_TOP;
    end else if (exc_entry) begin
      saved_q <= mask_q;
      if (auto_mask_en) mask_q <= LVL_TOP;
    end else if (exc_return) begin
      mask_q <= saved_q;
    end else if (mask_wr) begin
      mask_q <= mask_wdata;
    end
  end

  AST_AUTO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && auto_mask_en) |=> (mask_q == LVL_TOP)); // R8
  AST_ENTRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && !auto_mask_en) |=> $stable(mask_q)); // R8
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !exc_entry && !exc_return) |=> (mask_q == $past(mask_wdata))); // R2
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_t req_level,
  input  lvl_t mask_q,
  input  logic top_live,
  input  logic first_instr,
  input  logic exc_entry,
  output logic take_top,
  output logic accept_q
);
  logic await_q, take_now, take_low;

  assign take_low = beats_mask(req_level, mask_q);
  assign take_now = !first_instr && !await_q && (top_live || take_low);
  assign take_top = take_now && top_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      accept_q <= take_now;
      if (take_now)       await_q <= 1'b1;
      else if (exc_entry) await_q <= 1'b0;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |=> !accept_q); // R11
  AST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    first_instr |=> !accept_q); // R5
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    await_q |=> !accept_q); // R7
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (take_now && !top_live) |-> (req_level > mask_q)); // R3
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LVL_W-1:0]    req_level,
  input  logic                mask_wr,
  input  logic [LVL_W-1:0]    mask_wdata,
  input  logic                exc_entry,
  input  logic                first_instr,
  input  logic                exc_return,
  input  logic                auto_mask_en,
  output logic                accept,
  output logic [LVL_W-1:0]    cur_mask
);
  lvl_t mask_w;
  logic top_live_w, take_top_w;

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .exc_entry(exc_entry), .exc_return(exc_return),
    .auto_mask_en(auto_mask_en), .mask_q(mask_w)
  );

  irq_top_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req_level(req_level),
    .first_instr(first_instr), .take_top(take_top_w), .top_live(top_live_w)
  );

  irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req_level(req_level), .mask_q(mask_w),
    .top_live(top_live_w), .first_instr(first_instr), .exc_entry(exc_entry),
    .take_top(take_top_w), .accept_q(accept)
  );

  assign cur_mask = mask_w;

  AST_RESET_MASK: assert property (@(posedge clk)
    $rose(rst_n) |-> (cur_mask == LVL_TOP)); // R1
endmodule

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req_level = '0, mask_wdata = '0;
  logic mask_wr = 0, exc_entry = 0, first_instr = 0, exc_return = 0, auto_mask_en = 0;
  logic accept;
  logic [2:0] cur_mask;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_accept_ctrl dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic entry(input logic auto);
    exc_entry = 1; auto_mask_en = auto; step(); exc_entry = 0;
  endtask

  task automatic t_reset();
    chk("R1 mask", cur_mask, 7);
    chk("R1 accept", accept, 0);
  endtask

  task automatic t_write();
    mask_wr = 1; mask_wdata = 3; step(); mask_wr = 0;
    chk("R2 mask write", cur_mask, 3);
  endtask

  task automatic t_maskable();
    req_level = 3; step(); chk("R3 equal level", accept, 0);
    req_level = 2; step(); chk("R3 below mask", accept, 0);
    req_level = 4; step(); chk("R3 above mask", accept, 1);
    step(); chk("R11 pulse width", accept, 0);
    step(); chk("R7 awaiting entry", accept, 0);
    entry(1); chk("R8 auto raise", cur_mask, 7);
    step(); chk("R8 masked after raise", accept, 0);
    req_level = 0;
    exc_return = 1; step(); exc_return = 0;
    chk("R9 restore", cur_mask, 3);
    entry(0); chk("R8 no auto keeps mask", cur_mask, 3);
    mask_wr = 1; mask_wdata = 0; step(); mask_wr = 0;
    step(); chk("R3 level zero", accept, 0);
  endtask

  task automatic t_top();
    mask_wr = 1; mask_wdata = 7; step(); mask_wr = 0;
    req_level = 7; step(); chk("R4 edge beats mask 7", accept, 1);
    entry(0); chk("R7 no accept during entry", accept, 0);
    for (int i = 0; i < 3; i++) begin
      step(); chk("R4 held level no retrigger", accept, 0);
    end
    req_level = 0; step();
    first_instr = 1; req_level = 7; step(); chk("R5 inhibited edge", accept, 0);
    step(); chk("R6 still held", accept, 0);
    first_instr = 0; step(); chk("R6 pending taken", accept, 1);
    req_level = 0; entry(0);
  endtask

  task automatic t_inhibit_low();
    mask_wr = 1; mask_wdata = 0; step(); mask_wr = 0;
    req_level = 5; first_instr = 1; step(); chk("R5 maskable inhibited", accept, 0);
    first_instr = 0; step(); chk("R5 taken after window", accept, 1);
    req_level = 0; entry(0);
  endtask

  task automatic t_priority();
    mask_wr = 1; mask_wdata = 4; step(); mask_wr = 0;
    exc_entry = 1; exc_return = 1; mask_wr = 1; mask_wdata = 2; auto_mask_en = 1;
    step(); exc_entry = 0; exc_return = 0; mask_wr = 0;
    chk("R10 entry wins", cur_mask, 7);
    exc_return = 1; mask_wr = 1; mask_wdata = 1; step(); exc_return = 0; mask_wr = 0;
    chk("R10 return beats write", cur_mask, 4);
    mask_wr = 1; mask_wdata = 6; step(); mask_wr = 0;
    chk("R2 second write", cur_mask, 6);
  endtask

  initial begin
    #5000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_write();
    t_maskable();
    t_top();
    t_inhibit_low();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule